// File: doc/BRIEF.md
# Bus-Width Matching Port Adapter

This block sits between a storage queue that always moves 36-bit words and an outside port whose width is chosen at reset. The outside port can be 36, 18 or 9 bits wide. In the two narrow widths, each 36-bit word is split into pieces: two pieces of 18 bits, or four pieces of 9 bits. A configuration bit selects whether the most significant piece or the least significant piece travels first.

On the inbound path, pieces arriving from the outside port are collected into a holding register. The full word goes to the queue only in the cycle the final piece is accepted. On the outbound path, the word at the head of the queue is handed out one piece at a time. The head is released only when its final piece is taken.

A small sequencing counter on each path tracks the piece position. The width and order settings are captured while reset is asserted and then held. All handshakes are combinational through the block, so the adapter adds no cycle of latency.

Top module: `bus_match_adapter`

## Requirements
- R1: `cfg_width` and `cfg_big_end` are captured on every clock edge while `rst_n` is low. Changes to them while `rst_n` is high have no effect on the sequencing or on the data.
- R2: Width code 2'b00 selects 36-bit mode. Each accepted inbound transfer writes `in_data` to the queue in the same cycle. Each accepted outbound request presents the full head word and releases it.
- R3: Width code 2'b01 selects 18-bit mode, with two pieces per word. Pieces enter on `in_data[17:0]` and bits above 17 are ignored. Pieces leave on `out_data[17:0]` with bits above 17 driven to zero.
- R4: Width code 2'b10 selects 9-bit mode, with four pieces per word. Pieces use bits [8:0] and all other inbound bits are ignored. All other outbound bits read zero.
- R5: With `cfg_big_end`=1, the first piece of a word is its most significant piece and the pieces continue toward the least significant.
- R6: With `cfg_big_end`=0, the first piece of a word is its least significant piece and the pieces continue toward the most significant.
- R7: `fifo_wr_en` is raised only in the cycle the final piece of a word is accepted, with the whole assembled word on `fifo_wr_data`. No partial word is ever written.
- R8: `in_ready` is low only when the next piece would complete a word and `fifo_full` is high. Non-final pieces are accepted while the queue is full.
- R9: `out_valid` equals not `fifo_empty`. A piece is taken when `out_req` and `out_valid` are both high. `fifo_rd_en` is raised only when the final piece of the head word is taken.
- R10: Reset returns both piece counters to the first piece and discards any partly assembled word.
- R11: Width code 2'b11 behaves as 36-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_width | input | 2 | Port width code: 00=36, 01=18, 10=9, 11=36 |
| cfg_big_end | input | 1 | 1: most significant piece first; 0: least significant piece first |
| in_valid | input | 1 | Outside port offers an inbound piece |
| in_data | input | 36 | Inbound piece, right-aligned |
| in_ready | output | 1 | Adapter accepts the inbound piece this cycle |
| fifo_wr_en | output | 1 | Write one assembled word into the queue |
| fifo_wr_data | output | 36 | Assembled word |
| fifo_full | input | 1 | Queue cannot take a word |
| fifo_rd_en | output | 1 | Release the head word of the queue |
| fifo_rd_data | input | 36 | Head word of the queue (show-ahead) |
| fifo_empty | input | 1 | Queue holds no word |
| out_req | input | 1 | Outside port takes the offered outbound piece |
| out_valid | output | 1 | An outbound piece is offered |
| out_data | output | 36 | Outbound piece, right-aligned, upper bits zero |

## Verification
Two events can fall in the same cycle:
- a word completing on the inbound path while the queue is full, and
- the outbound path releasing a head word.

Both paths are driven every cycle with independent random valid and request patterns. The modelled queue is drained and refilled at random, so commits, stalls and releases coincide often.

The test is judged cycle by cycle against a bench model:
- `in_ready` must fall exactly when the final piece meets a full queue.
- The commit and release strobes must appear exactly on final pieces.
- The committed word and every outbound piece must match values the bench computes from the configured width and order.

// File: rtl/bm_pkg.sv
// Package: shared type for the bus-width matching adapter.
// Assumes: a word splits into four equal lanes; the narrow widths use two
// lanes (half word) or one lane (quarter word) per piece.
package bm_pkg;

    // Captured port width after mapping of the raw configuration code.
    typedef enum logic [1:0] {
        BM_W36 = 2'b00,
        BM_W18 = 2'b01,
        BM_W9  = 2'b10
    } bm_width_e;

endpackage

// File: rtl/bm_cfg_latch.sv
// Module: captures the width and piece-order settings while reset is low
// and holds them afterwards.
// Assumes: the configuration inputs are stable for at least one clock edge
// inside the reset pulse.
module bm_cfg_latch
    import bm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_width,
    input  logic       cfg_big_end,
    output bm_width_e  mode_q,
    output logic       big_q
);

    // Sample the settings on every edge during reset; the unused code maps to full width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            case (cfg_width)
                2'b01:   mode_q <= BM_W18;
                2'b10:   mode_q <= BM_W9;
                default: mode_q <= BM_W36;
            endcase
            big_q <= cfg_big_end;
        end
    end

endmodule

// File: rtl/bm_piece_ctr.sv
// Module: sequences piece positions within one word and converts the
// transfer position to the lane-group slot it occupies, honouring the order.
// Assumes: LANES is a power of two and at least four; mode is static
// outside reset.
module bm_piece_ctr
    import bm_pkg::*;
#(
    parameter int LANES = 4,
    localparam int CNT_W = $clog2(LANES)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  bm_width_e        mode,
    input  logic             big,
    input  logic             step,
    output logic [CNT_W-1:0] slot,
    output logic             last
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_idx;

    // Highest piece index for the configured width.
    always_comb begin
        case (mode)
            BM_W18:  last_idx = CNT_W'(LANES / 2 - 1);
            BM_W9:   last_idx = CNT_W'(LANES - 1);
            default: last_idx = '0;
        endcase
    end

    // Final-piece flag and the slot the current piece maps onto.
    always_comb begin
        last = (cnt == last_idx);
        slot = big ? (last_idx - cnt) : cnt;
    end

    // Advance on each accepted piece, wrapping after the final one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/bm_pack.sv
// Module: inbound path. Collects narrow pieces into a holding register and
// writes the full word to the queue when the final piece is accepted.
// Assumes: pieces are right-aligned on in_data; the queue write is taken in
// the same cycle fifo_wr_en is high.
module bm_pack
    import bm_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int LANES  = 4,
    localparam int LW    = WORD_W / LANES,
    localparam int CNT_W = $clog2(LANES)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  bm_width_e         mode,
    input  logic              big,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              fifo_full,
    output logic              fifo_wr_en,
    output logic [WORD_W-1:0] fifo_wr_data
);

    logic [CNT_W-1:0]  slot;
    logic              last;
    logic              accept;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] asm_w;
    int unsigned       sh;

    bm_piece_ctr #(.LANES(LANES)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .big   (big),
        .step  (accept),
        .slot  (slot),
        .last  (last)
    );

    // Log2 of lanes per piece for the configured width.
    always_comb begin
        case (mode)
            BM_W18:  sh = CNT_W - 1;
            BM_W9:   sh = 0;
            default: sh = CNT_W;
        endcase
    end

    // Handshake: only a completing piece needs room in the queue.
    always_comb begin
        in_ready   = !(last && fifo_full);
        accept     = in_valid && in_ready;
        fifo_wr_en = accept && last;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [LW-1:0] lane_v;

        // Lane takes the incoming piece if it belongs to the current slot, else keeps the held value.
        always_comb begin
            int unsigned lslot;
            int unsigned sub;
            lslot = j >> sh;
            sub   = j - (lslot << sh);
            if (lslot == 32'(slot)) begin
                lane_v = in_data[sub*LW +: LW];
            end else begin
                lane_v = acc[j*LW +: LW];
            end
        end

        assign asm_w[j*LW +: LW] = lane_v;
    end

    assign fifo_wr_data = asm_w;

    // Holding register: keeps partial words, cleared on commit and on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (accept) begin
            acc <= last ? '0 : asm_w;
        end
    end

endmodule

// File: rtl/bm_unpack.sv
// Module: outbound path. Presents the head word one piece at a time and
// releases the head when its final piece is taken.
// Assumes: fifo_rd_data shows the head word whenever fifo_empty is low and
// the release takes effect on the clock edge of fifo_rd_en.
module bm_unpack
    import bm_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int LANES  = 4,
    localparam int LW    = WORD_W / LANES,
    localparam int CNT_W = $clog2(LANES)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  bm_width_e         mode,
    input  logic              big,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_rd_data,
    output logic              fifo_rd_en,
    input  logic              out_req,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);

    logic [CNT_W-1:0] slot;
    logic             last;
    logic             take;
    int unsigned      sh;

    bm_piece_ctr #(.LANES(LANES)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .big   (big),
        .step  (take),
        .slot  (slot),
        .last  (last)
    );

    // Log2 of lanes per piece for the configured width.
    always_comb begin
        case (mode)
            BM_W18:  sh = CNT_W - 1;
            BM_W9:   sh = 0;
            default: sh = CNT_W;
        endcase
    end

    // Handshake: a piece is taken on request while a word is present.
    always_comb begin
        out_valid  = !fifo_empty;
        take       = out_req && !fifo_empty;
        fifo_rd_en = take && last;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LW-1:0] lane_v;

        // Output lane i carries lane (slot * piece_lanes + i) of the head word, or zero above the piece.
        always_comb begin
            int unsigned src;
            src = (32'(slot) << sh) + i;
            if (i < (1 << sh)) begin
                lane_v = fifo_rd_data[src*LW +: LW];
            end else begin
                lane_v = '0;
            end
        end

        assign out_data[i*LW +: LW] = lane_v;
    end

endmodule

// File: rtl/bus_match_adapter.sv
// Module: top of the bus-width matching adapter. Joins the configuration
// capture, the inbound packer and the outbound unpacker.
// Assumes: one clock for port and queue side; the queue is show-ahead on
// read and writes on the edge of fifo_wr_en.
module bus_match_adapter
    import bm_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int LANES  = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_big_end,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              fifo_wr_en,
    output logic [WORD_W-1:0] fifo_wr_data,
    input  logic              fifo_full,
    output logic              fifo_rd_en,
    input  logic [WORD_W-1:0] fifo_rd_data,
    input  logic              fifo_empty,
    input  logic              out_req,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);

    bm_width_e mode_q;
    logic      big_q;

    bm_cfg_latch u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_width   (cfg_width),
        .cfg_big_end (cfg_big_end),
        .mode_q      (mode_q),
        .big_q       (big_q)
    );

    bm_pack #(.WORD_W(WORD_W), .LANES(LANES)) u_pack (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode_q),
        .big          (big_q),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .fifo_full    (fifo_full),
        .fifo_wr_en   (fifo_wr_en),
        .fifo_wr_data (fifo_wr_data)
    );

    bm_unpack #(.WORD_W(WORD_W), .LANES(LANES)) u_unpack (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode_q),
        .big          (big_q),
        .fifo_empty   (fifo_empty),
        .fifo_rd_data (fifo_rd_data),
        .fifo_rd_en   (fifo_rd_en),
        .out_req      (out_req),
        .out_valid    (out_valid),
        .out_data     (out_data)
    );

endmodule

// File: rtl/bm_adapter_checker.sv
// Checker: temporal properties of the adapter, bound to the top module.
module bm_adapter_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       big,
    input logic       in_valid,
    input logic       in_ready,
    input logic       fifo_wr_en,
    input logic       fifo_full,
    input logic       fifo_rd_en,
    input logic       fifo_empty,
    input logic       out_req
);

    assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(mode) && $stable(big)));

    assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && in_valid && in_ready) |-> fifo_wr_en);

    assert_no_back_to_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && fifo_wr_en) |=> !fifo_wr_en);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> !fifo_full);

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |-> (!fifo_empty && out_req));

    assert_release_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && fifo_rd_en) |=> !fifo_rd_en);

endmodule

bind bus_match_adapter bm_adapter_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_q),
    .big        (big_q),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .fifo_wr_en (fifo_wr_en),
    .fifo_full  (fifo_full),
    .fifo_rd_en (fifo_rd_en),
    .fifo_empty (fifo_empty),
    .out_req    (out_req)
);

// File: tb/tb_bus_match_adapter.sv
module tb_bus_match_adapter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_width = 2'b00;
    logic        cfg_big_end = 1'b0;
    logic        in_valid = 1'b0;
    logic [35:0] in_data = '0;
    logic        in_ready;
    logic        fifo_wr_en;
    logic [35:0] fifo_wr_data;
    logic        fifo_full = 1'b0;
    logic        fifo_rd_en;
    logic [35:0] fifo_rd_data = '0;
    logic        fifo_empty = 1'b1;
    logic        out_req = 1'b0;
    logic        out_valid;
    logic [35:0] out_data;

    int total = 0;
    int bad = 0;

    // Bench model state
    int          n_pcs = 1;
    bit          big = 1'b0;
    logic [35:0] wword;
    int          wk = 0;
    int          wcnt = 0;
    logic [35:0] rq[$];
    int          rk = 0;
    string       mtag = "R2";
    string       etag = "R6";
    string       xtag = "";

    always #2 clk = ~clk;

    bus_match_adapter dut (
        .clk (clk), .rst_n (rst_n), .cfg_width (cfg_width), .cfg_big_end (cfg_big_end),
        .in_valid (in_valid), .in_data (in_data), .in_ready (in_ready),
        .fifo_wr_en (fifo_wr_en), .fifo_wr_data (fifo_wr_data), .fifo_full (fifo_full),
        .fifo_rd_en (fifo_rd_en), .fifo_rd_data (fifo_rd_data), .fifo_empty (fifo_empty),
        .out_req (out_req), .out_valid (out_valid), .out_data (out_data)
    );

    function automatic int pieces_of(input logic [1:0] code);
        case (code)
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 1;
        endcase
    endfunction

    function automatic logic [35:0] mask_of(input int n);
        logic [63:0] m;
        m = (64'd1 << (36 / n)) - 64'd1;
        return m[35:0];
    endfunction

    // Piece sent or received at transfer position k of word w.
    function automatic logic [35:0] piece_of(input logic [35:0] w, input int n, input bit b, input int k);
        int slot;
        slot = b ? (n - 1 - k) : k;
        return (w >> (slot * (36 / n))) & mask_of(n);
    endfunction

    function automatic logic [35:0] rnd36();
        return {$urandom(), $urandom()} & 36'hF_FFFF_FFFF;
    endfunction

    task automatic check(input string what, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic sync_model();
        fifo_full    = (wcnt >= 2);
        fifo_empty   = (rq.size() == 0);
        fifo_rd_data = (rq.size() == 0) ? 36'h0 : rq[0];
    endtask

    // One clock of stimulus on both paths, checked against the model.
    task automatic cycle(input bit dw, input bit dr, input bit churn);
        bit          wlast, exp_rdy, empty;
        logic [35:0] junk;
        @(negedge clk);
        junk     = rnd36();
        in_valid = dw;
        in_data  = (junk & ~mask_of(n_pcs)) | piece_of(wword, n_pcs, big, wk);
        out_req  = dr;
        #1;
        wlast   = (wk == n_pcs - 1);
        exp_rdy = !(wlast && fifo_full);
        empty   = (rq.size() == 0);
        check("R8 in_ready", {35'd0, in_ready}, {35'd0, exp_rdy});
        check("R7 fifo_wr_en", {35'd0, fifo_wr_en}, {35'd0, dw && exp_rdy && wlast});
        if (dw && exp_rdy && wlast)
            check($sformatf("%s/%s%s assembled word", mtag, etag, xtag), fifo_wr_data, wword);
        check("R9 out_valid", {35'd0, out_valid}, {35'd0, !empty});
        if (!empty)
            check($sformatf("%s/%s outbound piece", mtag, etag), out_data, piece_of(rq[0], n_pcs, big, rk));
        check("R9 fifo_rd_en", {35'd0, fifo_rd_en}, {35'd0, dr && !empty && (rk == n_pcs - 1)});
        @(posedge clk);
        #1;
        if (dw && exp_rdy) begin
            if (wlast) begin
                wk = 0; wword = rnd36(); wcnt++;
            end else begin
                wk++;
            end
        end
        if (dr && !empty) begin
            if (rk == n_pcs - 1) begin
                void'(rq.pop_front()); rk = 0;
            end else begin
                rk++;
            end
        end
        if (churn) begin
            if (wcnt > 0 && ($urandom() % 3) == 0) wcnt--;
            if (rq.size() < 4 && ($urandom() % 2) == 0) rq.push_back(rnd36());
        end
        sync_model();
    endtask

    // Reset with a configuration, then scramble the configuration inputs (R1).
    task automatic do_reset(input logic [1:0] code, input bit b);
        @(negedge clk);
        rst_n = 1'b0; cfg_width = code; cfg_big_end = b;
        in_valid = 1'b0; out_req = 1'b0;
        wk = 0; rk = 0; wcnt = 0; rq.delete(); wword = rnd36();
        n_pcs = pieces_of(code); big = (n_pcs == 1) ? 1'b0 : b;
        mtag = (n_pcs == 1) ? ((code == 2'b11) ? "R11" : "R2") : (n_pcs == 2) ? "R3" : "R4";
        etag = b ? "R5" : "R6";
        sync_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cfg_width = 2'($urandom()); cfg_big_end = 1'($urandom());
        #1;
        check("R10 reset out_valid", {35'd0, out_valid}, 36'd0);
        check("R10 reset fifo_wr_en", {35'd0, fifo_wr_en}, 36'd0);
        check("R10 reset in_ready", {35'd0, in_ready}, 36'd1);
    endtask

    task automatic run_cfg(input logic [1:0] code, input bit b, input int cycles);
        do_reset(code, b);
        for (int c = 0; c < cycles; c++) begin
            cycle(($urandom() % 4) != 0, ($urandom() % 4) != 0, 1'b1);
            if ((c % 500) == 250) begin
                cfg_width = 2'($urandom()); cfg_big_end = 1'($urandom());
            end
        end
    endtask

    initial begin
        #(4 * 190000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        process::self().srandom(32'd20240611);
        wword = rnd36();

        // Directed: full-width pass-through with queue full stalls (R2, R8).
        do_reset(2'b00, 1'b0);
        wcnt = 2; sync_model();
        cycle(1'b1, 1'b0, 1'b0);
        wcnt = 0; sync_model();
        cycle(1'b1, 1'b0, 1'b0);

        // Directed: non-final pieces accepted while queue full, final stalls (R8).
        do_reset(2'b10, 1'b1);
        wcnt = 2; sync_model();
        for (int k = 0; k < 5; k++) cycle(1'b1, 1'b0, 1'b0);
        wcnt = 0; sync_model();
        cycle(1'b1, 1'b0, 1'b0);

        // Directed: reset in mid-word discards the partial word (R10).
        do_reset(2'b10, 1'b0);
        cycle(1'b1, 1'b0, 1'b0);
        cycle(1'b1, 1'b0, 1'b0);
        do_reset(2'b10, 1'b0);
        xtag = "/R10";
        for (int k = 0; k < 4; k++) cycle(1'b1, 1'b0, 1'b0);
        xtag = "";

        // Directed: outbound half-word pieces then reset mid-word (R10, R3).
        do_reset(2'b01, 1'b1);
        rq.push_back(36'h9_ABCD_1234); sync_model();
        cycle(1'b0, 1'b1, 1'b0);
        do_reset(2'b01, 1'b1);
        rq.push_back(36'h1_2345_6789); sync_model();
        cycle(1'b0, 1'b1, 1'b0);
        cycle(1'b0, 1'b1, 1'b0);

        // Random runs over every configuration.
        run_cfg(2'b00, 1'b0, 2500);
        run_cfg(2'b01, 1'b1, 2500);
        run_cfg(2'b01, 1'b0, 2500);
        run_cfg(2'b10, 1'b1, 2500);
        run_cfg(2'b10, 1'b0, 2500);
        run_cfg(2'b11, 1'b1, 2500);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule